// File: doc/BRIEF.md
# Block Address Translation Matcher

This block performs the block-translation step of a 32-bit address translation path. It keeps two small arrays of entries, one consulted by instruction fetches and one by loads and stores. Each entry is a pair of 32-bit words. The upper word names an effective block and its size, and it carries two valid bits: one for user mode and one for privileged mode. The lower word supplies the physical block number and a two-bit protection code. A configuration port writes one word of one entry per cycle.

Each cycle a request may present an effective address, the access type and the privilege state. One cycle later the block answers with a hit flag, the number of the winning entry, the physical page address and the granted rights. If the granted rights do not cover the access, it also raises a violation flag. A miss tells the next stage (segment and page-table translation, which is not part of this block) to carry on. A violating hit is still reported as a hit, so that no page-table search follows.

Top module: `bat_matcher`

## Requirements
- R1: After reset every entry of both arrays is zero, so every lookup misses until software writes an entry.
- R2: A fetch (`req_fetch`=1) searches only the instruction array, and a load or store searches only the data array. `cfg_ifetch`=1 writes the instruction array, and `cfg_hi`=1 selects the upper word.
- R3: An entry takes part in a lookup only if its user-valid bit (upper bit 0) is set when `req_user`=1, or its privileged-valid bit (upper bit 1) is set when `req_user`=0.
- R4: The compare mask is 0xFFFE0000 AND NOT(L << 15), where L is the 11-bit block-length field in upper bits 12:2. An entry matches when (EA AND mask) equals (upper AND 0xFFFE0000).
- R5: The physical page is ((lower AND mask) OR (EA AND NOT mask)) with bits 11:0 cleared.
- R6: Rights come from the lower-word code in bits 1:0. Code 0 grants nothing, codes 1 and 3 grant read and execute, and code 2 grants read, write and execute. `rsp_rights` bit 0 is read, bit 1 is write and bit 2 is execute.
- R7: When several entries match, the lowest-numbered one wins, and its number is given on `rsp_idx`.
- R8: `rsp_violation` is 1 on a hit whose rights lack the needed right: execute for a fetch, write for a store, read for a load. The hit flag stays set in that case.
- R9: On a miss, `rsp_page`, `rsp_rights`, `rsp_idx` and `rsp_violation` are all zero.
- R10: A response appears on the cycle after `req_valid`, with `rsp_valid` high for exactly that cycle. A configuration write affects lookups presented on later cycles, not a lookup presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_ifetch | input | 1 | 1 = instruction array, 0 = data array |
| cfg_idx | input | IDXW | Entry number to write |
| cfg_hi | input | 1 | 1 = upper word, 0 = lower word |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_store | input | 1 | Request is a store (ignored for fetches) |
| req_user | input | 1 | Request is made in user mode |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | IDXW | Number of the winning entry |
| rsp_page | output | 32 | Physical page address |
| rsp_rights | output | 3 | Granted rights {execute, write, read} |
| rsp_violation | output | 1 | Hit whose rights do not cover the access |

## Verification
The bench programs overlapping entries of different sizes. A design that resolved priority wrongly would return the higher-numbered entry or merge the two physical addresses. Every address is looked up in both privilege states and with all three access types. That exposes a design that consults the wrong valid bit or the wrong array: it would hit where it should miss. The bench also steps through block lengths from the smallest to the largest, which catches a mask shifted by one position or a physical address that takes the wrong bits from the entry. A write presented in the same cycle as a lookup checks that a design forwarding the new value early, or delaying it by a cycle too many, is caught.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned PAGE_BITS  = 12;
  localparam int unsigned LEN_LSB    = 2;
  localparam int unsigned LEN_W      = 11;
  localparam int unsigned LEN_SHIFT  = 15;
  localparam int unsigned VLD_SUP    = 1;
  localparam int unsigned VLD_USR    = 0;
  localparam logic [WORD_W-1:0] BLK_MASK  = 32'hFFFE_0000;
  localparam logic [WORD_W-1:0] PAGE_MASK = ~((32'd1 << PAGE_BITS) - 32'd1);

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  function automatic rights_t code_rights(input logic [1:0] code);
    rights_t g;
    g.r = (code != 2'd0);
    g.x = (code != 2'd0);
    g.w = (code == 2'd2);
    return g;
  endfunction
endpackage

// File: rtl/bat_pair_bank.sv
module bat_pair_bank #(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned IDXW      = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    we,
  input  logic [IDXW-1:0]                         idx,
  input  logic                                    hi,
  input  logic [bat_pkg::WORD_W-1:0]              wdata,
  output logic [N_ENTRIES-1:0][bat_pkg::WORD_W-1:0] upper_q,
  output logic [N_ENTRIES-1:0][bat_pkg::WORD_W-1:0] lower_q
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic en_up, en_lo;
    logic [bat_pkg::WORD_W-1:0] up_d, lo_d;

    always_comb begin
      en_up = we &&  hi && (idx == IDXW'(g));
      en_lo = we && !hi && (idx == IDXW'(g));
      up_d  = en_up ? wdata : upper_q[g];
      lo_d  = en_lo ? wdata : lower_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        upper_q[g] <= '0;
        lower_q[g] <= '0;
      end else begin
        if (en_up) upper_q[g] <= up_d;
        if (en_lo) lower_q[g] <= lo_d;
      end
    end
  end
endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
  import bat_pkg::*;
(
  input  logic [WORD_W-1:0] upper,
  input  logic [WORD_W-1:0] lower,
  input  logic [WORD_W-1:0] ea,
  input  logic              user,
  output logic              hit,
  output logic [WORD_W-1:0] page,
  output logic [2:0]        rights
);
  logic [LEN_W-1:0]  blen;
  logic [WORD_W-1:0] len_ext;
  logic [WORD_W-1:0] mask;
  logic              vld;
  rights_t           g;

  always_comb begin
    blen    = upper[LEN_LSB +: LEN_W];
    len_ext = {{(WORD_W-LEN_W){1'b0}}, blen};
    mask    = BLK_MASK & ~(len_ext << LEN_SHIFT);
    vld     = user ? upper[VLD_USR] : upper[VLD_SUP];
    hit     = vld && ((ea & mask) == (upper & BLK_MASK));
    page    = ((lower & mask) | (ea & ~mask)) & PAGE_MASK;
    g       = code_rights(lower[1:0]);
    rights  = g;
  end
endmodule

// File: rtl/bat_prio_pick.sv
module bat_prio_pick #(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned IDXW      = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0]                      hits,
  input  logic [N_ENTRIES-1:0][bat_pkg::WORD_W-1:0] pages,
  input  logic [N_ENTRIES-1:0][2:0]                 rights,
  output logic                                      any,
  output logic [IDXW-1:0]                           idx,
  output logic [bat_pkg::WORD_W-1:0]                page,
  output logic [2:0]                                rts
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    page = '0;
    rts  = '0;
    for (int i = N_ENTRIES-1; i >= 0; i--) begin
      if (hits[i]) begin
        any  = 1'b1;
        idx  = IDXW'(i);
        page = pages[i];
        rts  = rights[i];
      end
    end
  end
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher #(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned IDXW      = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_ifetch,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic            cfg_hi,
  input  logic [31:0]     cfg_wdata,
  input  logic            req_valid,
  input  logic            req_fetch,
  input  logic            req_store,
  input  logic            req_user,
  input  logic [31:0]     req_ea,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [IDXW-1:0] rsp_idx,
  output logic [31:0]     rsp_page,
  output logic [2:0]      rsp_rights,
  output logic            rsp_violation
);
  import bat_pkg::*;

  logic [N_ENTRIES-1:0][WORD_W-1:0] i_up, i_lo, d_up, d_lo, s_up, s_lo;
  logic [N_ENTRIES-1:0][WORD_W-1:0] e_page;
  logic [N_ENTRIES-1:0][2:0]        e_rts;
  logic [N_ENTRIES-1:0]             e_hit;

  bat_pair_bank #(.N_ENTRIES(N_ENTRIES), .IDXW(IDXW)) u_ibank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_ifetch), .idx(cfg_idx),
    .hi(cfg_hi), .wdata(cfg_wdata), .upper_q(i_up), .lower_q(i_lo)
  );

  bat_pair_bank #(.N_ENTRIES(N_ENTRIES), .IDXW(IDXW)) u_dbank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we && !cfg_ifetch), .idx(cfg_idx),
    .hi(cfg_hi), .wdata(cfg_wdata), .upper_q(d_up), .lower_q(d_lo)
  );

  always_comb begin
    s_up = req_fetch ? i_up : d_up;
    s_lo = req_fetch ? i_lo : d_lo;
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    bat_entry_match u_match (
      .upper(s_up[g]), .lower(s_lo[g]), .ea(req_ea), .user(req_user),
      .hit(e_hit[g]), .page(e_page[g]), .rights(e_rts[g])
    );
  end

  logic            p_any;
  logic [IDXW-1:0] p_idx;
  logic [31:0]     p_page;
  logic [2:0]      p_rts;

  bat_prio_pick #(.N_ENTRIES(N_ENTRIES), .IDXW(IDXW)) u_pick (
    .hits(e_hit), .pages(e_page), .rights(e_rts),
    .any(p_any), .idx(p_idx), .page(p_page), .rts(p_rts)
  );

  rights_t         need;
  logic            vld_d, hit_d, viol_d;
  logic [IDXW-1:0] idx_d;
  logic [31:0]     page_d;
  logic [2:0]      rts_d;
  logic            res_en;

  always_comb begin
    need   = '0;
    if (req_fetch)      need.x = 1'b1;
    else if (req_store) need.w = 1'b1;
    else                need.r = 1'b1;
    res_en = req_valid;
    vld_d  = req_valid;
    hit_d  = p_any;
    idx_d  = p_idx;
    page_d = p_page;
    rts_d  = p_rts;
    viol_d = p_any && ((need & ~p_rts) != 3'b000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit       <= 1'b0;
      rsp_idx       <= '0;
      rsp_page      <= '0;
      rsp_rights    <= '0;
      rsp_violation <= 1'b0;
    end else if (res_en) begin
      rsp_hit       <= hit_d;
      rsp_idx       <= idx_d;
      rsp_page      <= page_d;
      rsp_rights    <= rts_d;
      rsp_violation <= viol_d;
    end
  end
endmodule

// File: rtl/bat_matcher_chk.sv
module bat_matcher_chk #(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned IDXW      = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            cfg_ifetch,
  input logic [IDXW-1:0] cfg_idx,
  input logic            cfg_hi,
  input logic [31:0]     cfg_wdata,
  input logic            req_valid,
  input logic            req_fetch,
  input logic            req_store,
  input logic            req_user,
  input logic [31:0]     req_ea,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [IDXW-1:0] rsp_idx,
  input logic [31:0]     rsp_page,
  input logic [2:0]      rsp_rights,
  input logic            rsp_violation
);
  // R10: one response per request, one cycle later
  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R8: a violation is always a hit
  a_r8_violation_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_violation |-> rsp_hit);
  // R8: store violation tracks the write right
  a_r8_store_viol: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && $past(req_store) && !$past(req_fetch)
      |-> rsp_violation == !rsp_rights[1]);
  // R8: fetch violation tracks the execute right
  a_r8_fetch_viol: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && $past(req_fetch) |-> rsp_violation == !rsp_rights[2]);
  // R9: a miss carries zero data
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_page == 32'd0 && rsp_rights == 3'd0
      && rsp_idx == '0 && !rsp_violation);
  // R5: page aligned
  a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_page[11:0] == 12'd0);
  // R6: rights are one of the three legal sets
  a_r6_rights_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rights == 3'b000 || rsp_rights == 3'b101
      || rsp_rights == 3'b111));
endmodule

bind bat_matcher bat_matcher_chk #(.N_ENTRIES(N_ENTRIES), .IDXW(IDXW)) u_chk (.*);

// File: tb/bat_matcher_bench.sv
module bat_matcher_bench;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_ifetch, cfg_hi;
  logic [IW-1:0] cfg_idx;
  logic [31:0] cfg_wdata;
  logic req_valid, req_fetch, req_store, req_user;
  logic [31:0] req_ea;
  logic rsp_valid, rsp_hit, rsp_violation;
  logic [IW-1:0] rsp_idx;
  logic [31:0] rsp_page;
  logic [2:0] rsp_rights;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_up [2][N];
  logic [31:0] m_lo [2][N];

  always #2.5 clk = ~clk;

  bat_matcher #(.N_ENTRIES(N), .IDXW(IW)) u_bat_matcher (.*);

  typedef struct packed {
    logic hit; logic [IW-1:0] idx; logic [31:0] page; logic [2:0] rts; logic viol;
  } res_t;

  function automatic res_t model(input bit f, input bit s, input bit u, input logic [31:0] ea);
    res_t r = '0;
    int side = f ? 1 : 0;
    for (int i = N-1; i >= 0; i--) begin
      logic [31:0] up = m_up[side][i];
      logic [31:0] lo = m_lo[side][i];
      logic [31:0] mk = 32'hFFFE0000 & ~({21'd0, up[12:2]} << 15);
      bit v = u ? up[0] : up[1];
      if (v && ((ea & mk) == (up & 32'hFFFE0000))) begin
        r.hit = 1; r.idx = IW'(i);
        r.page = ((lo & mk) | (ea & ~mk)) & 32'hFFFFF000;
        case (lo[1:0])
          2'd0: r.rts = 3'b000;
          2'd2: r.rts = 3'b111;
          default: r.rts = 3'b101;
        endcase
      end
    end
    if (r.hit) r.viol = f ? !r.rts[2] : (s ? !r.rts[1] : !r.rts[0]);
    return r;
  endfunction

  task automatic cfg(input bit side, input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ifetch = side; cfg_idx = IW'(idx); cfg_hi = hi; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (hi) m_up[side][idx] = d; else m_lo[side][idx] = d;
  endtask

  task automatic cmp(input string tag, input res_t e);
    res_t a;
    a = {rsp_hit, rsp_idx, rsp_page, rsp_rights, rsp_violation};
    n_chk++;
    if (!rsp_valid || a !== e) begin
      n_fail++;
      $display("FAIL %s ea=%h vld=%b act=%h exp=%h", tag, req_ea, rsp_valid, a, e);
    end
  endtask

  task automatic look(input string tag, input bit f, input bit s, input bit u, input logic [31:0] ea);
    res_t e;
    @(negedge clk);
    req_valid = 1; req_fetch = f; req_store = s; req_user = u; req_ea = ea;
    e = model(f, s, u, ea);
    @(negedge clk);
    req_valid = 0;
    cmp(tag, e);
  endtask

  task automatic sweep(input string tag);
    logic [31:0] bases [5] = '{32'h1000_0000, 32'h2000_0000, 32'h4000_0000, 32'h0, 32'h3FFF_0000};
    for (int b = 0; b < 5; b++)
      for (int k = 0; k < 12; k++)
        for (int u = 0; u < 2; u++)
          for (int t = 0; t < 3; t++)
            look(tag, t == 2, t == 1, u[0], bases[b] + k * 32'h0003_1A35);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [10:0] lens [8] = '{11'h000, 11'h001, 11'h003, 11'h00F, 11'h03F, 11'h0FF, 11'h3FF, 11'h7FF};
    res_t e_old, e_new;
    rst_n = 0; cfg_we = 0; cfg_ifetch = 0; cfg_idx = '0; cfg_hi = 0; cfg_wdata = '0;
    req_valid = 0; req_fetch = 0; req_store = 0; req_user = 0; req_ea = '0;
    for (int s = 0; s < 2; s++) for (int i = 0; i < N; i++) begin m_up[s][i] = '0; m_lo[s][i] = '0; end
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin n_fail++; $display("FAIL R1 reset vld act=%b exp=0", rsp_valid); end
    rst_n = 1;
    // R1: empty arrays miss everywhere
    look("R1", 0, 0, 0, 32'h1000_0000);
    look("R1", 1, 0, 1, 32'h0000_0000);
    look("R9", 0, 1, 0, 32'hFFFF_F000);

    // data side: overlapping entries for R7, privilege split for R3
    cfg(0, 0, 1, 32'h1000_0000 | (11'h000 << 2) | 32'h2);  // priv only
    cfg(0, 0, 0, 32'h8000_0000 | 32'h2);
    cfg(0, 1, 1, 32'h1000_0000 | (11'h003 << 2) | 32'h3);
    cfg(0, 1, 0, 32'h9000_0000 | 32'h1);
    cfg(0, 2, 1, 32'h2000_0000 | (11'h7FF << 2) | 32'h1);  // user only
    cfg(0, 2, 0, 32'hA000_0000 | 32'h0);
    cfg(0, 3, 1, 32'h4000_0000 | (11'h00F << 2) | 32'h3);
    cfg(0, 3, 0, 32'hC000_0000 | 32'h3);
    // instruction side
    cfg(1, 0, 1, 32'h1000_0000 | (11'h001 << 2) | 32'h3);
    cfg(1, 0, 0, 32'h5000_0000 | 32'h1);
    cfg(1, 1, 1, 32'h4000_0000 | (11'h0FF << 2) | 32'h2);
    cfg(1, 1, 0, 32'h6000_0000 | 32'h0);
    cfg(1, 3, 1, 32'h2000_0000 | (11'h3FF << 2) | 32'h1);
    cfg(1, 3, 0, 32'h7000_0000 | 32'h2);

    // R7: priv sees entry 0, user sees entry 1
    look("R7", 0, 0, 0, 32'h1001_2345);
    look("R7", 0, 0, 1, 32'h1001_2345);
    // R2, R3, R4, R5, R6, R8 over the sweep
    sweep("R2/R3/R4/R5/R6/R8");

    // R4, R5: every block length on data entry 3
    for (int l = 0; l < 8; l++) begin
      cfg(0, 3, 1, 32'h4000_0000 | ({21'd0, lens[l]} << 2) | 32'h3);
      for (int k = 0; k < 16; k++) begin
        look("R4", 0, 0, 0, 32'h4000_0000 + k * 32'h0102_0F01);
        look("R5", 0, 1, 1, 32'h3FFE_0000 + k * 32'h0002_0800);
      end
    end

    // R10: write and lookup in the same cycle
    @(negedge clk);
    e_old = model(0, 0, 0, 32'h4000_1000);
    cfg_we = 1; cfg_ifetch = 0; cfg_idx = 2'd3; cfg_hi = 0; cfg_wdata = 32'hE000_0002;
    req_valid = 1; req_fetch = 0; req_store = 0; req_user = 0; req_ea = 32'h4000_1000;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    m_lo[0][3] = 32'hE000_0002;
    cmp("R10 same-cycle", e_old);
    e_new = model(0, 0, 0, 32'h4000_1000);
    look("R10 next", 0, 0, 0, 32'h4000_1000);
    n_chk++;
    if (e_new.page == e_old.page) begin n_fail++; $display("FAIL R10 stimulus act=%h exp=differs", e_new.page); end
    // R10: no response without a request
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin n_fail++; $display("FAIL R10 idle act=%b exp=0", rsp_valid); end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule